// File: doc/BRIEF.md
# Transmit Checksum Inserter

This block sits in the transmit path ahead of the MAC. For each outgoing frame it first takes a short control header, then the frame bytes, and keeps the whole frame in a local buffer. When the header asks for checksum insertion, the block adds up the frame as big-endian 16-bit words from a chosen start offset to the end of the frame. It adds a 16-bit seed, folds the carries back in and inverts the result. It then replaces two bytes of the frame with that value at a chosen write offset. The frame goes downstream only after its last byte has arrived, so the patched bytes can lie anywhere in the frame.

Three configuration pins control the block. One enables transmission. The other two allow jumbo frames and VLAN-tagged frames; while both are low, frames slightly longer than the standard maximum are dropped. A malformed control header also causes a drop. Every frame ends with a one-cycle completion pulse that tells whether the frame was sent or dropped and whether its header was bad. A running count of transmitted bytes is updated on each sent frame.

Top module: `tx_csum_insert`

## Requirements
- R1: A header is exactly five 32-bit control words, the fifth marked by `ctl_last`. Bit 0 of word 0 requests insertion. Word 1 holds the sum start offset in bits 31:16 and the write offset in bits 15:0. Word 2 holds the seed in bits 15:0. Words 3 and 4 and all other bits are ignored.
- R2: The inserted value is the complement of the folded ones' complement sum of two things: the frame bytes from the start offset to the end of the frame, paired as big-endian 16-bit words with an odd last byte padded by a zero low byte, and the seed. A start offset at or past the end of the frame sums the seed alone.
- R3: The high byte of the result replaces the frame byte at the write offset and the low byte replaces the byte at write offset + 1. Either position that lies past the end of the frame is skipped, and every other byte leaves unchanged. The sum always uses the bytes as received.
- R4: When bit 0 of word 0 is clear, the frame is sent unchanged.
- R5: When `tx_enable` is low at the end of a frame, the frame is dropped with no output.
- R6: When `jumbo_en` and `vlan_en` are both low, frames of 1519 to 1522 bytes are dropped. Frames of 1518 or 1523 bytes, and any length while either pin is high, are sent.
- R7: A header of any length other than five words causes the following frame to be dropped, with `done_err` high in its completion pulse.
- R8: The first output byte is valid two cycles after the last input byte is accepted. `in_ready` is high only while frame bytes are being collected, and `ctl_ready` only while a header is awaited.
- R9: `done` pulses for one cycle. For a sent frame it comes one cycle after the last output handshake, with `done_sent` high. For a dropped frame it comes two cycles after the last input byte, with `done_sent` low. `tx_bytes` grows by the frame length on sent frames only, in the same cycle as the pulse.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values.
- R11: After reset, `ctl_ready` is high, `in_ready`, `out_valid` and `done` are low, and `tx_bytes` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_enable | input | 1 | Transmission allowed; sampled at the end of a frame |
| jumbo_en | input | 1 | Long frames allowed |
| vlan_en | input | 1 | Tagged-length frames allowed |
| ctl_valid | input | 1 | Control word valid |
| ctl_ready | output | 1 | Header accepted in this state |
| ctl_data | input | 32 | Control word |
| ctl_last | input | 1 | Last control word of the header |
| in_valid | input | 1 | Frame byte valid |
| in_ready | output | 1 | Frame byte accepted |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Last frame byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the byte |
| out_data | output | 8 | Output byte, patched |
| out_last | output | 1 | Last output byte of the frame |
| done | output | 1 | One-cycle completion pulse |
| done_sent | output | 1 | Frame was sent (valid with `done`) |
| done_err | output | 1 | Header length was wrong (valid with `done`) |
| tx_bytes | output | CNT_W | Running total of transmitted bytes |

## Verification
The reference model records the cycle in which the last frame byte is accepted. It expects the first output byte, or the completion pulse of a dropped frame, exactly one sampling cycle later, which is two clock edges after that handshake. For a sent frame, the completion pulse and the new byte total are expected in the sample right after the last output handshake. Every output byte is compared against the model's patched copy in the cycle in which it is handed over. Downstream readiness is varied on a fixed pattern, so each of these timing checks also runs under backpressure.

// File: rtl/txcs_pkg.sv
// Shared types and arithmetic for the transmit checksum inserter.
// Assumes the running sum never exceeds 32 bits (frames of at most 64 KiB).
package txcs_pkg;

    typedef enum logic [1:0] {
        ST_HDR,     // awaiting control words
        ST_DATA,    // collecting frame bytes
        ST_DECIDE,  // length known, choose send or drop
        ST_SEND     // streaming the patched frame out
    } txcs_state_e;

    localparam int          HDR_WORDS        = 5;
    localparam logic [15:0] STD_FRAME_MAX    = 16'd1518;
    localparam logic [15:0] TAGGED_FRAME_MAX = 16'd1522;

    // Adds the seed, folds carries until none remain, returns the complement.
    function automatic logic [15:0] fold_and_invert(input logic [31:0] acc,
                                                    input logic [15:0] seed);
        logic [17:0] a;
        logic [16:0] b;
        logic [15:0] c;
        a = 18'(acc[31:16]) + 18'(acc[15:0]) + 18'(seed);
        b = 17'(a[15:0]) + 17'(a[17:16]);
        c = b[15:0] + 16'(b[16]);
        return ~c;
    endfunction

endpackage

// File: rtl/txcs_hdr.sv
// Control header capture: stores insert enable, offsets and seed from a
// header of control words and flags any header whose length is not five.
// Assumes the caller only asserts take while a header is being accepted.
module txcs_hdr
    import txcs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        take,
    input  logic [31:0] word,
    input  logic        last,
    output logic        csum_en,
    output logic [15:0] start_off,
    output logic [15:0] wr_off,
    output logic [15:0] seed,
    output logic        bad
);
    localparam int CNT_W = $clog2(HDR_WORDS + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(HDR_WORDS - 1);
    localparam logic [CNT_W-1:0] SAT_IDX  = CNT_W'(HDR_WORDS);

    logic [CNT_W-1:0] idx_q;

    // Word index, field capture and length check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q     <= '0;
            csum_en   <= 1'b0;
            start_off <= '0;
            wr_off    <= '0;
            seed      <= '0;
            bad       <= 1'b0;
        end else if (take) begin
            case (idx_q)
                CNT_W'(0): csum_en <= word[0];
                CNT_W'(1): begin
                    start_off <= word[31:16];
                    wr_off    <= word[15:0];
                end
                CNT_W'(2): seed <= word[15:0];
                default: ;
            endcase
            if (last) begin
                idx_q <= '0;
                bad   <= (idx_q != LAST_IDX);
            end else if (idx_q != SAT_IDX) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/txcs_sum.sv
// Running ones' complement accumulator: adds each byte at or past the start
// offset into a wide sum, as the high byte of a 16-bit word when its distance
// from the start is even and as the low byte otherwise.
// Assumes clear is raised before the first byte of each frame.
module txcs_sum #(
    parameter int LEN_W = 16,
    parameter int SUM_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             take,
    input  logic [LEN_W-1:0] idx,
    input  logic [7:0]       data,
    input  logic [LEN_W-1:0] start,
    output logic [SUM_W-1:0] sum
);
    logic        in_range;
    logic        high_half;
    logic [15:0] addend;

    // Byte placement within its 16-bit word.
    always_comb begin
        in_range  = (idx >= start);
        high_half = (idx[0] == start[0]);
        addend    = high_half ? {data, 8'h00} : {8'h00, data};
    end

    // Accumulate.
    always_ff @(posedge clk) begin
        if (!rst_n)                sum <= '0;
        else if (clear)            sum <= '0;
        else if (take && in_range) sum <= sum + SUM_W'(addend);
    end

endmodule

// File: rtl/txcs_buf.sv
// Single-frame byte store: one write port, one asynchronous read port.
// Assumes frames are no longer than DEPTH bytes.
module txcs_buf #(
    parameter int DEPTH = 2048,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    // Store incoming bytes.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Read the byte being sent.
    assign rdata = mem[raddr];

endmodule

// File: rtl/tx_csum_insert.sv
// Transmit checksum inserter top. It takes a five-word header, collects a
// frame, decides send or drop once the length is known, and streams the frame
// out with the checksum bytes replaced. It assumes frames fit in MAX_BYTES and
// that the configuration pins are stable around the end of a frame.
module tx_csum_insert
    import txcs_pkg::*;
#(
    parameter int MAX_BYTES = 2048,
    parameter int CNT_W     = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_enable,
    input  logic             jumbo_en,
    input  logic             vlan_en,
    input  logic             ctl_valid,
    output logic             ctl_ready,
    input  logic [31:0]      ctl_data,
    input  logic             ctl_last,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_data,
    output logic             out_last,
    output logic             done,
    output logic             done_sent,
    output logic             done_err,
    output logic [CNT_W-1:0] tx_bytes
);
    localparam int LEN_W = 16;
    localparam int SUM_W = 32;
    localparam int AW    = $clog2(MAX_BYTES);

    txcs_state_e      state_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] rd_q;
    logic [15:0]      csum_q;
    logic             csum_en, hdr_bad;
    logic [15:0]      start_off, wr_off, seed;
    logic [SUM_W-1:0] sum;
    logic [7:0]       buf_byte;
    logic             ctl_take, hdr_end, in_take, out_take;
    logic             drop, hit_hi, hit_lo;

    // Handshakes and state-driven readiness.
    always_comb begin
        ctl_ready = (state_q == ST_HDR);
        in_ready  = (state_q == ST_DATA);
        out_valid = (state_q == ST_SEND);
        ctl_take  = ctl_valid && ctl_ready;
        hdr_end   = ctl_take && ctl_last;
        in_take   = in_valid && in_ready;
        out_take  = out_valid && out_ready;
    end

    txcs_hdr u_hdr (
        .clk(clk), .rst_n(rst_n), .take(ctl_take), .word(ctl_data),
        .last(ctl_last), .csum_en(csum_en), .start_off(start_off),
        .wr_off(wr_off), .seed(seed), .bad(hdr_bad)
    );

    txcs_sum #(.LEN_W(LEN_W), .SUM_W(SUM_W)) u_sum (
        .clk(clk), .rst_n(rst_n), .clear(hdr_end), .take(in_take),
        .idx(len_q), .data(in_data), .start(start_off), .sum(sum)
    );

    txcs_buf #(.DEPTH(MAX_BYTES), .AW(AW)) u_buf (
        .clk(clk), .we(in_take && (len_q < LEN_W'(MAX_BYTES))),
        .waddr(len_q[AW-1:0]), .wdata(in_data),
        .raddr(rd_q[AW-1:0]), .rdata(buf_byte)
    );

    // Drop decision and output patch selection.
    always_comb begin
        drop = hdr_bad || !tx_enable ||
               (!jumbo_en && !vlan_en &&
                len_q > STD_FRAME_MAX && len_q <= TAGGED_FRAME_MAX);
        hit_hi = csum_en && ({1'b0, rd_q} == {1'b0, wr_off});
        hit_lo = csum_en && ({1'b0, rd_q} == ({1'b0, wr_off} + 17'd1));
        out_data = hit_hi ? csum_q[15:8] : (hit_lo ? csum_q[7:0] : buf_byte);
        out_last = (rd_q == len_q - 1'b1);
    end

    // Frame sequencing, completion report and byte total.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_HDR;
            len_q     <= '0;
            rd_q      <= '0;
            csum_q    <= '0;
            done      <= 1'b0;
            done_sent <= 1'b0;
            done_err  <= 1'b0;
            tx_bytes  <= '0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_HDR: if (hdr_end) begin
                    len_q   <= '0;
                    state_q <= ST_DATA;
                end
                ST_DATA: if (in_take) begin
                    len_q <= len_q + 1'b1;
                    if (in_last) state_q <= ST_DECIDE;
                end
                ST_DECIDE: begin
                    if (drop) begin
                        done      <= 1'b1;
                        done_sent <= 1'b0;
                        done_err  <= hdr_bad;
                        state_q   <= ST_HDR;
                    end else begin
                        csum_q  <= fold_and_invert(sum, seed);
                        rd_q    <= '0;
                        state_q <= ST_SEND;
                    end
                end
                ST_SEND: if (out_take) begin
                    rd_q <= rd_q + 1'b1;
                    if (out_last) begin
                        done      <= 1'b1;
                        done_sent <= 1'b1;
                        done_err  <= 1'b0;
                        tx_bytes  <= tx_bytes + CNT_W'(len_q);
                        state_q   <= ST_HDR;
                    end
                end
                default: state_q <= ST_HDR;
            endcase
        end
    end

endmodule

// File: rtl/tx_csum_insert_chk.sv
// Port-level protocol checker for the transmit checksum inserter, bound to
// every instance of the top module.
module tx_csum_insert_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_ready,
    input logic             in_valid,
    input logic             in_ready,
    input logic             in_last,
    input logic             out_valid,
    input logic             out_ready,
    input logic [7:0]       out_data,
    input logic             out_last,
    input logic             done,
    input logic             done_sent,
    input logic             done_err,
    input logic [CNT_W-1:0] tx_bytes
);
    // R8
    out_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && in_ready && in_last, 2));

    // R8
    phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && ctl_ready) && !(in_ready && out_valid));

    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_data) && $stable(out_last)));

    // R9
    done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_sent) |-> $past(out_valid && out_ready && out_last));

    // R9
    bytes_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_bytes != $past(tx_bytes)) |-> (done && done_sent));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    err_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_err) |-> !done_sent);

endmodule

bind tx_csum_insert tx_csum_insert_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_ready(ctl_ready), .in_valid(in_valid),
    .in_ready(in_ready), .in_last(in_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .done(done), .done_sent(done_sent), .done_err(done_err),
    .tx_bytes(tx_bytes)
);

// File: tb/tb_tx_csum_insert.sv
// Bench: a behavioural model keeps queues of expected output bytes and
// completion reports and is compared with the design on every clock.
module tb_tx_csum_insert;
    localparam int MAXB  = 2048;
    localparam int CW    = 32;
    localparam int LIMIT = 150000;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          tx_enable = 1'b1, jumbo_en = 1'b0, vlan_en = 1'b0;
    logic          ctl_valid = 1'b0, ctl_last = 1'b0;
    logic [31:0]   ctl_data = '0;
    logic          ctl_ready;
    logic          in_valid = 1'b0, in_last = 1'b0;
    logic [7:0]    in_data = '0;
    logic          in_ready;
    logic          out_valid, out_last;
    logic          out_ready = 1'b0;
    logic [7:0]    out_data;
    logic          done, done_sent, done_err;
    logic [CW-1:0] tx_bytes;

    tx_csum_insert #(.MAX_BYTES(MAXB), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .jumbo_en(jumbo_en),
        .vlan_en(vlan_en), .ctl_valid(ctl_valid), .ctl_ready(ctl_ready),
        .ctl_data(ctl_data), .ctl_last(ctl_last), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last), .done(done), .done_sent(done_sent),
        .done_err(done_err), .tx_bytes(tx_bytes)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int          checks = 0, fails = 0;
    byte unsigned exp_q[$];
    bit          exp_sent[$], exp_err[$];
    int          exp_len[$];
    longint      exp_total = 0;
    int          last_in_cyc = 0, last_out_cyc = 0, done_seen = 0;
    bit          first_pend = 1'b0;
    string       cur_tag = "R11";

    task automatic chk(string tag, longint act, longint exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        if (cyc == LIMIT) begin
            chk(cur_tag, 0, 1, "watchdog expired");
            summary();
        end
    end

    // Per-clock comparison of the output stream and completion reports.
    always @(negedge clk) begin
        if (rst_n) begin
            out_ready = ((cyc % 7) != 3) && ((cyc % 13) != 5);
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    chk(cur_tag, 1, 0, "unexpected out_valid");
                end else begin
                    if (first_pend) begin
                        chk(cur_tag, cyc, last_in_cyc + 1, "R8 output start cycle");
                        first_pend = 1'b0;
                    end
                    if (out_ready) begin
                        automatic byte unsigned eb = exp_q.pop_front();
                        chk(cur_tag, out_data, eb, "R10 output byte");
                        chk(cur_tag, out_last, exp_q.size() == 0, "last flag");
                        if (exp_q.size() == 0) last_out_cyc = cyc + 1;
                    end
                end
            end
            if (done) begin
                if (exp_sent.size() == 0) begin
                    chk(cur_tag, 1, 0, "unexpected done");
                end else begin
                    automatic bit s = exp_sent.pop_front();
                    automatic bit e = exp_err.pop_front();
                    automatic int l = exp_len.pop_front();
                    chk(cur_tag, done_sent, s, "R9 done_sent");
                    chk(cur_tag, done_err, e, "R7 done_err");
                    chk(cur_tag, cyc, s ? last_out_cyc : last_in_cyc + 1,
                        "R9 done cycle");
                    if (s) exp_total += l;
                    chk(cur_tag, tx_bytes, exp_total, "R9 byte total");
                end
                done_seen++;
            end
        end
    end

    // Builds one frame, predicts the result, drives header and bytes, waits for done.
    task automatic run_frame(string tag, int nwords, bit cen, int start, int wr,
                             int seed, int len, int pat, bit ten, bit jum, bit vl);
        byte unsigned f[];
        byte unsigned g[];
        longint s;
        int target;
        bit drop;
        logic [31:0] w;
        f = new[len];
        for (int i = 0; i < len; i++)
            f[i] = (pat == 0) ? 8'hFF : 8'((i * pat + 17 + (i >> 3)) & 255);
        g = new[len](f);
        if (cen) begin
            s = 0;
            for (int i = start; i < len; i += 2)
                s += (longint'(f[i]) << 8) + ((i + 1 < len) ? f[i + 1] : 0);
            s += seed & 16'hFFFF;
            while (s > 16'hFFFF) s = (s & 16'hFFFF) + (s >> 16);
            s = (~s) & 16'hFFFF;
            if (wr < len)     g[wr]     = 8'(s >> 8);
            if (wr + 1 < len) g[wr + 1] = 8'(s & 255);
        end
        drop = (nwords != 5) || !ten ||
               (!jum && !vl && len >= 1519 && len <= 1522);
        if (!drop) begin
            for (int i = 0; i < len; i++) exp_q.push_back(g[i]);
            first_pend = 1'b1;
        end
        exp_sent.push_back(!drop);
        exp_err.push_back(nwords != 5);
        exp_len.push_back(len);
        cur_tag = tag;
        target = done_seen + 1;

        @(negedge clk);
        tx_enable = ten; jumbo_en = jum; vlan_en = vl;
        for (int k = 0; k < nwords; k++) begin
            case (k)
                0:       w = 32'h5A5A_0F00 | 32'(cen);
                1:       w = {16'(start), 16'(wr)};
                2:       w = {16'hBEEF, 16'(seed)};
                default: w = 32'hC0DE_0000 + 32'(k);
            endcase
            if (k > 0) @(negedge clk);
            ctl_valid = 1'b1; ctl_data = w; ctl_last = (k == nwords - 1);
            while (!ctl_ready) @(negedge clk);
        end
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            ctl_valid = 1'b0; ctl_last = 1'b0;
            in_valid = 1'b1; in_data = f[i]; in_last = (i == len - 1);
            while (!in_ready) @(negedge clk);
            if (i == len - 1) last_in_cyc = cyc + 1;
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        while (done_seen < target) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11", ctl_ready, 1, "ctl_ready after reset");
        chk("R11", in_ready, 0, "in_ready after reset");
        chk("R11", out_valid, 0, "out_valid after reset");
        chk("R11", done, 0, "done after reset");
        chk("R11", tx_bytes, 0, "tx_bytes after reset");

        // R1 field positions, R2 even region, seed
        run_frame("R1", 5, 1, 14, 24, 16'h1234, 60, 5, 1, 0, 0);
        // R2 odd byte count in the summed region
        run_frame("R2", 5, 1, 20, 50, 16'h0000, 61, 11, 1, 0, 0);
        // R2 start past the end: seed alone
        run_frame("R2", 5, 1, 70, 10, 16'h5555, 64, 3, 1, 0, 0);
        // R2 heavy carries: all bytes 0xFF, seed 0xFFFF
        run_frame("R2", 5, 1, 0, 30, 16'hFFFF, 40, 0, 1, 0, 0);
        // R3 write offset at the last byte: only the high byte lands
        run_frame("R3", 5, 1, 10, 59, 16'h0042, 60, 7, 1, 0, 0);
        // R3 write offset beyond the frame: nothing patched
        run_frame("R3", 5, 1, 10, 200, 16'h0042, 60, 9, 1, 0, 0);
        // R3 write offset inside the summed region
        run_frame("R3", 5, 1, 4, 6, 16'h0101, 33, 13, 1, 0, 0);
        // R4 insertion disabled
        run_frame("R4", 5, 0, 14, 24, 16'h1234, 60, 5, 1, 0, 0);
        // R5 transmit disabled
        run_frame("R5", 5, 1, 14, 24, 16'h1234, 60, 5, 0, 0, 0);
        // R6 length window
        run_frame("R6", 5, 1, 14, 24, 16'h0007, 1518, 3, 1, 0, 0);
        run_frame("R6", 5, 1, 14, 24, 16'h0007, 1519, 3, 1, 0, 0);
        run_frame("R6", 5, 1, 14, 24, 16'h0007, 1522, 3, 1, 0, 0);
        run_frame("R6", 5, 1, 14, 24, 16'h0007, 1523, 3, 1, 0, 0);
        run_frame("R6", 5, 1, 14, 24, 16'h0007, 1520, 5, 1, 0, 1);
        run_frame("R6", 5, 1, 14, 24, 16'h0007, 1521, 5, 1, 1, 0);
        // R7 short and long headers
        run_frame("R7", 4, 1, 14, 24, 16'h1234, 60, 5, 1, 0, 0);
        run_frame("R7", 6, 1, 14, 24, 16'h1234, 60, 5, 1, 0, 0);
        // R9 counting resumes after drops
        run_frame("R9", 5, 1, 2, 0, 16'h8000, 20, 21, 1, 0, 0);

        repeat (4) @(negedge clk);
        chk("R9", exp_q.size(), 0, "output bytes outstanding");
        chk("R9", exp_sent.size(), 0, "completions outstanding");
        summary();
    end

endmodule